// File: doc/BRIEF.md
# Keyed-Lock Page Permission Controller

This block guards a local memory that is split into equal pages. It keeps one permission attribute per page and checks every access against it. Each access carries the requester's privilege mode, its kind (read, write or execute) and whether it comes from the local CPU. The block answers with a grant or a deny one cycle later, and it records the first denied access for software to inspect.

The attribute table can be read at any time. It can only be changed while a 128-bit key lock is open. Software writes the key as four 32-bit words and then issues a lock command. From then on, table writes are ignored. They stay ignored until an unlock command is issued while the key registers hold exactly the same 128 bits. The page count, page size and base address are parameters.

Top module: `pgperm_guard`

## Requirements
- R1: After reset the lock is open (status register 0x05 bit0 = 0), no fault is held (`fault_flag` = 0, fault status 0x07 reads 0), and every table entry reads `RESET_ATTR` (default 0x13F).
- R2: Register map, word addressed. Table entry i is at 0x80+i. The key words are at 0x00..0x03 and read as zero. The lock command is at 0x04, lock status at 0x05, fault address at 0x06, fault status at 0x07 and fault clear at 0x08. While the lock is open, a table write stores bits 8 and 5:0 of the data and reads the other bits back as zero. Writes to an index at or above `NPAGES` are dropped, and such indices read as zero.
- R3: A write to 0x04 with bit1 set copies the current 128-bit key into a reference and closes the lock, so status bit0 reads 1. Bit1 takes precedence over bit0 in the same write.
- R4: While the lock is closed, table writes leave every entry unchanged, and table reads still return the stored values.
- R5: A write to 0x04 with bit0 set (bit1 clear) opens the lock only if the key registers equal the stored reference. Otherwise the lock stays closed.
- R6: A write to 0x04 with bit2 set clears all four key registers after any lock or unlock in the same write has used their old contents.
- R7: The attribute bits are bit0 user execute, bit1 user write, bit2 user read, bit3 supervisor execute, bit4 supervisor write and bit5 supervisor read. Access kind 0 is read, 1 is write, 2 is execute, and 3 is reserved and always denied. An access is granted only if the bit for its mode and kind is set. `resp_valid` and `resp_deny` appear on the clock edge after `acc_valid`.
- R8: An access with `acc_local` = 1 is denied when bit8 of the page's attribute is clear, even if the mode bits allow it.
- R9: The page index is (address − `BASE_ADDR`) >> `PAGE_SHIFT`. An address below the base, or one whose index is at or above `NPAGES`, is denied.
- R10: The first denied access is captured in the same edge as its response. The fault address register gets the access address. The fault status register gets bits 1:0 = kind, bit2 = supervisor, bit3 = local, bit4 = out of range and bit8 = valid. `fault_flag` rises. Later denials do not change the captured fault.
- R11: Any write to 0x08 clears the held fault, so `fault_flag` drops and both fault registers read 0. If a denial arrives in the same cycle as the clear, that denial is captured instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| acc_valid | input | 1 | Memory access to check this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_super | input | 1 | Requester is in supervisor mode |
| acc_local | input | 1 | Requester is the local CPU |
| resp_valid | output | 1 | Response for the previous cycle's access |
| resp_deny | output | 1 | That access was denied |
| fault_flag | output | 1 | A captured fault is held |

## Verification
A wrong lock state shows up at the first table write after the lock command, when the next read of that entry returns a stale or altered value. It also shows up at once in status bit0. A wrong reference key cannot be seen until an unlock is attempted, so the stimulus pairs matching and non-matching key sets before each unlock. A corrupted attribute or a wrong decode shows as a wrong `resp_deny` one cycle after the access. A capture error shows in the fault registers on the next read, and a later denial that overwrites the captured fault is caught by reading back after a second denial.

// File: rtl/pp_pkg.sv
// Shared definitions for the page permission controller.
// Assumes a word-addressed register space with the table in the upper half.
package pp_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int ATTR_W    = 9;
    localparam logic [ATTR_W-1:0] ATTR_MASK = 9'h13F;
    localparam int BIT_LOCAL = 8;

    localparam logic [3:0] OFF_CMD   = 4'h4;
    localparam logic [3:0] OFF_STAT  = 4'h5;
    localparam logic [3:0] OFF_FADDR = 4'h6;
    localparam logic [3:0] OFF_FSTAT = 4'h7;
    localparam logic [3:0] OFF_FCLR  = 4'h8;

    localparam int CMD_UNLOCK = 0;
    localparam int CMD_LOCK   = 1;
    localparam int CMD_KCLR   = 2;
endpackage

// File: rtl/pp_keylock.sv
// Key registers, reference key and lock flag.
// Assumes key writes and command writes never occur in the same cycle.
module pp_keylock #(
    parameter int KEY_WORDS = 4,
    parameter int KW        = 32,
    localparam int KSW      = $clog2(KEY_WORDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           key_we,
    input  logic [KSW-1:0] key_sel,
    input  logic [KW-1:0]  wdata,
    input  logic           cmd_we,
    input  logic [2:0]     cmd,
    output logic           locked
);
    import pp_pkg::*;

    logic [KEY_WORDS-1:0][KW-1:0] key_q;
    logic [KEY_WORDS-1:0][KW-1:0] ref_q;

    // Key words: loaded by software, cleared by the key-reset command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (cmd_we && cmd[CMD_KCLR]) begin
            key_q <= '0;
        end else if (key_we) begin
            key_q[key_sel] <= wdata;
        end
    end

    // Lock state: lock stores the reference, unlock compares against it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q  <= '0;
            locked <= 1'b0;
        end else if (cmd_we) begin
            if (cmd[CMD_LOCK]) begin
                ref_q  <= key_q;
                locked <= 1'b1;
            end else if (cmd[CMD_UNLOCK] && (key_q == ref_q)) begin
                locked <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pp_table.sv
// Per-page attribute storage with write gating by the lock.
// Assumes the caller has already range-checked wr_en against NPAGES.
module pp_table #(
    parameter int NPAGES             = 16,
    parameter logic [8:0] RESET_ATTR = 9'h13F,
    localparam int IDXW              = (NPAGES > 1) ? $clog2(NPAGES) : 1,
    localparam int AW                = pp_pkg::ATTR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 locked,
    input  logic [IDXW-1:0]      wr_idx,
    input  logic [AW-1:0]        wr_attr,
    input  logic [IDXW-1:0]      rd_idx,
    input  logic [IDXW-1:0]      lk_idx,
    output logic [AW-1:0]        rd_attr,
    output logic [AW-1:0]        lk_attr,
    output logic [NPAGES*AW-1:0] attr_flat
);
    import pp_pkg::*;

    logic [AW-1:0] ent [NPAGES];

    for (genvar i = 0; i < NPAGES; i++) begin : g_ent
        // One entry: updated only while open and addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent[i] <= RESET_ATTR & ATTR_MASK;
            end else if (wr_en && !locked && (wr_idx == IDXW'(i))) begin
                ent[i] <= wr_attr & ATTR_MASK;
            end
        end
        assign attr_flat[i*AW +: AW] = ent[i];
    end

    // Two read ports: register readback and access lookup.
    always_comb begin
        rd_attr = '0;
        lk_attr = '0;
        if (32'(rd_idx) < NPAGES) rd_attr = ent[rd_idx];
        if (32'(lk_idx) < NPAGES) lk_attr = ent[lk_idx];
    end
endmodule

// File: rtl/pp_check.sv
// Combinational address decode and permission check for one access.
// Assumes the attribute input belongs to the page index it outputs.
module pp_check #(
    parameter int NPAGES          = 16,
    parameter int PAGE_SHIFT      = 12,
    parameter logic [31:0] BASE_ADDR = 32'h0080_0000,
    localparam int IDXW           = (NPAGES > 1) ? $clog2(NPAGES) : 1
) (
    input  logic [31:0]     acc_addr,
    input  logic [1:0]      acc_kind,
    input  logic            acc_super,
    input  logic            acc_local,
    input  logic [8:0]      attr,
    output logic [IDXW-1:0] idx,
    output logic            oor,
    output logic            deny
);
    import pp_pkg::*;

    logic [31:0] offset;
    logic [31:0] page;
    logic        mode_ok;

    // Page index and range test.
    always_comb begin
        offset = acc_addr - BASE_ADDR;
        page   = offset >> PAGE_SHIFT;
        oor    = (acc_addr < BASE_ADDR) || (page >= 32'(NPAGES));
        idx    = page[IDXW-1:0];
    end

    // Mode/kind bit selection, local gate, final verdict.
    always_comb begin
        unique case (acc_kind_e'(acc_kind))
            ACC_READ:  mode_ok = acc_super ? attr[5] : attr[2];
            ACC_WRITE: mode_ok = acc_super ? attr[4] : attr[1];
            ACC_EXEC:  mode_ok = acc_super ? attr[3] : attr[0];
            default:   mode_ok = 1'b0;
        endcase
        deny = oor || !mode_ok || (acc_local && !attr[BIT_LOCAL]);
    end
endmodule

// File: rtl/pp_fault.sv
// First-fault capture with software clear.
// Assumes a denial in a clear cycle should replace the cleared fault.
module pp_fault (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ev,
    input  logic [31:0] ev_addr,
    input  logic [31:0] ev_stat,
    input  logic        clr,
    output logic        held,
    output logic [31:0] faddr,
    output logic [31:0] fstat
);
    // Capture when free (or being freed), otherwise hold or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= 1'b0;
            faddr <= '0;
            fstat <= '0;
        end else if (ev && (!held || clr)) begin
            held  <= 1'b1;
            faddr <= ev_addr;
            fstat <= ev_stat;
        end else if (clr) begin
            held  <= 1'b0;
            faddr <= '0;
            fstat <= '0;
        end
    end
endmodule

// File: rtl/pgperm_guard.sv
// Top: register decode, readback mux and response register.
// Assumes NPAGES <= 2**(RAW-1) so every entry has a register address.
module pgperm_guard #(
    parameter int NPAGES             = 16,
    parameter int PAGE_SHIFT         = 12,
    parameter logic [31:0] BASE_ADDR = 32'h0080_0000,
    parameter logic [8:0] RESET_ATTR = 9'h13F,
    parameter int RAW                = 8,
    localparam int IDXW              = (NPAGES > 1) ? $clog2(NPAGES) : 1,
    localparam int AW                = pp_pkg::ATTR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           acc_valid,
    input  logic [31:0]    acc_addr,
    input  logic [1:0]     acc_kind,
    input  logic           acc_super,
    input  logic           acc_local,
    output logic           resp_valid,
    output logic           resp_deny,
    output logic           fault_flag
);
    import pp_pkg::*;

    logic                 tbl_hit, tbl_inrange, ctl_hit;
    logic [3:0]           ctl_off;
    logic                 lock_q;
    logic [AW-1:0]        rd_attr, lk_attr;
    logic [NPAGES*AW-1:0] attr_flat;
    logic [IDXW-1:0]      lk_idx;
    logic                 oor, deny;
    logic [31:0]          fault_addr_q, fault_stat_q, ev_stat;

    // Address decode for table and control registers.
    always_comb begin
        tbl_hit     = reg_addr[RAW-1];
        tbl_inrange = 32'(reg_addr[RAW-2:0]) < NPAGES;
        ctl_hit     = !reg_addr[RAW-1] && (reg_addr[RAW-2:4] == '0);
        ctl_off     = reg_addr[3:0];
    end

    pp_keylock #(.KEY_WORDS(4), .KW(32)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_we  (reg_wr && ctl_hit && (ctl_off < 4'h4)),
        .key_sel (ctl_off[1:0]),
        .wdata   (reg_wdata),
        .cmd_we  (reg_wr && ctl_hit && (ctl_off == OFF_CMD)),
        .cmd     (reg_wdata[2:0]),
        .locked  (lock_q)
    );

    pp_table #(.NPAGES(NPAGES), .RESET_ATTR(RESET_ATTR)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && tbl_hit && tbl_inrange),
        .locked    (lock_q),
        .wr_idx    (reg_addr[IDXW-1:0]),
        .wr_attr   (reg_wdata[AW-1:0]),
        .rd_idx    (reg_addr[IDXW-1:0]),
        .lk_idx    (lk_idx),
        .rd_attr   (rd_attr),
        .lk_attr   (lk_attr),
        .attr_flat (attr_flat)
    );

    pp_check #(.NPAGES(NPAGES), .PAGE_SHIFT(PAGE_SHIFT), .BASE_ADDR(BASE_ADDR)) u_chk_logic (
        .acc_addr  (acc_addr),
        .acc_kind  (acc_kind),
        .acc_super (acc_super),
        .acc_local (acc_local),
        .attr      (lk_attr),
        .idx       (lk_idx),
        .oor       (oor),
        .deny      (deny)
    );

    // Fault status word: kind, mode, origin, range, valid.
    always_comb begin
        ev_stat      = '0;
        ev_stat[1:0] = acc_kind;
        ev_stat[2]   = acc_super;
        ev_stat[3]   = acc_local;
        ev_stat[4]   = oor;
        ev_stat[8]   = 1'b1;
    end

    pp_fault u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (acc_valid && deny),
        .ev_addr (acc_addr),
        .ev_stat (ev_stat),
        .clr     (reg_wr && ctl_hit && (ctl_off == OFF_FCLR)),
        .held    (fault_flag),
        .faddr   (fault_addr_q),
        .fstat   (fault_stat_q)
    );

    // Response register: verdict one edge after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_deny  <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_deny  <= acc_valid && deny;
        end
    end

    // Register readback; key words read as zero.
    always_comb begin
        reg_rdata = '0;
        if (tbl_hit) begin
            if (tbl_inrange) reg_rdata[AW-1:0] = rd_attr;
        end else if (ctl_hit) begin
            unique case (ctl_off)
                OFF_STAT:  reg_rdata[0] = lock_q;
                OFF_FADDR: reg_rdata    = fault_addr_q;
                OFF_FSTAT: reg_rdata    = fault_stat_q;
                default:   reg_rdata    = '0;
            endcase
        end
    end
endmodule

// File: rtl/pp_guard_chk.sv
// Property checker for pgperm_guard, attached by bind.
module pp_guard_chk #(
    parameter int NPAGES = 16,
    parameter int RAW    = 8,
    localparam int AW    = pp_pkg::ATTR_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic [RAW-1:0]       reg_addr,
    input logic [31:0]          reg_wdata,
    input logic                 acc_valid,
    input logic                 resp_valid,
    input logic                 fault_flag,
    input logic                 locked,
    input logic [NPAGES*AW-1:0] attr_flat,
    input logic [31:0]          fault_addr
);
    logic cmd_wr, clr_wr;
    assign cmd_wr = reg_wr && (reg_addr == RAW'(8'h04));
    assign clr_wr = reg_wr && (reg_addr == RAW'(8'h08));

    a_r4_locked_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && reg_wr && reg_addr[RAW-1]) |=> $stable(attr_flat));

    a_r3_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[1]) |=> locked);

    a_r5_stays_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cmd_wr) |=> locked);

    a_r7_resp_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);

    a_r7_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);

    a_r10_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !clr_wr) |=> (fault_flag && $stable(fault_addr)));

    a_r10_rise_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> $past(acc_valid));

    a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !acc_valid) |=> !fault_flag);
endmodule

bind pgperm_guard pp_guard_chk #(.NPAGES(NPAGES), .RAW(RAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .acc_valid  (acc_valid),
    .resp_valid (resp_valid),
    .fault_flag (fault_flag),
    .locked     (lock_q),
    .attr_flat  (attr_flat),
    .fault_addr (fault_addr_q)
);

// File: tb/sim_pgperm_guard.sv
module sim_pgperm_guard;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 16;
    localparam int SH         = 12;
    localparam logic [31:0] BASE = 32'h0080_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        acc_valid = 1'b0, acc_super = 1'b0, acc_local = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        resp_valid, resp_deny, fault_flag;

    int n_chk = 0, n_bad = 0;

    logic [8:0]  m_attr [NP];
    logic [31:0] m_key [4];
    logic [31:0] m_ref [4];
    bit          m_locked;
    bit          m_fheld;
    logic [31:0] m_faddr, m_fstat;

    pgperm_guard u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_super(acc_super),
        .acc_local(acc_local), .resp_valid(resp_valid), .resp_deny(resp_deny),
        .fault_flag(fault_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit oor_of(input logic [31:0] a);
        return (a < BASE) || (((a - BASE) >> SH) >= NP);
    endfunction

    function automatic bit deny_of(input logic [31:0] a, input logic [1:0] k,
                                   input bit s, input bit l);
        logic [8:0] at;
        bit ok;
        if (oor_of(a)) return 1'b1;
        at = m_attr[(a - BASE) >> SH];
        case (k)
            2'd0: ok = s ? at[5] : at[2];
            2'd1: ok = s ? at[4] : at[1];
            2'd2: ok = s ? at[3] : at[0];
            default: ok = 1'b0;
        endcase
        return !ok || (l && !at[8]);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        // model update
        if (a[7]) begin
            if (a[6:0] < NP && !m_locked) m_attr[a[3:0]] = d[8:0] & 9'h13F;
        end else if (a < 8'h04) begin
            m_key[a[1:0]] = d;
        end else if (a == 8'h04) begin
            if (d[1]) begin
                for (int i = 0; i < 4; i++) m_ref[i] = m_key[i];
                m_locked = 1'b1;
            end else if (d[0] && m_key == m_ref) begin
                m_locked = 1'b0;
            end
            if (d[2]) for (int i = 0; i < 4; i++) m_key[i] = '0;
        end else if (a == 8'h08) begin
            m_fheld = 1'b0; m_faddr = '0; m_fstat = '0;
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic access(input string req, input logic [31:0] a, input logic [1:0] k,
                          input bit s, input bit l);
        bit d;
        d = deny_of(a, k, s, l);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_super = s; acc_local = l;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " resp_valid"}, 32'(resp_valid), 32'd1);
        check(req, 32'(resp_deny), 32'(d));
        if (d && !m_fheld) begin
            m_fheld = 1'b1;
            m_faddr = a;
            m_fstat = {23'd0, 1'b1, 3'd0, oor_of(a), l, s, k};
        end
    endtask

    task automatic fault_chk(input string req);
        check({req, " flag"}, 32'(fault_flag), 32'(m_fheld));
        rd_chk({req, " faddr"}, 8'h06, m_faddr);
        rd_chk({req, " fstat"}, 8'h07, m_fstat);
    endtask

    task automatic load_key(input logic [31:0] k0, k1, k2, k3);
        wr(8'h00, k0); wr(8'h01, k1); wr(8'h02, k2); wr(8'h03, k3);
    endtask

    function automatic logic [31:0] page_addr(input int p, input int off);
        return BASE + (32'(p) << SH) + 32'(off);
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < NP; i++) m_attr[i] = 9'h13F;
        for (int i = 0; i < 4; i++) begin m_key[i] = '0; m_ref[i] = '0; end
        m_locked = 0; m_fheld = 0; m_faddr = '0; m_fstat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 status", 8'h05, 32'd0);
        check("R1 flag", 32'(fault_flag), 32'd0);
        rd_chk("R1 fstat", 8'h07, 32'd0);
        rd_chk("R1 entry0", 8'h80, 32'h13F);
        rd_chk("R1 entry15", 8'h8F, 32'h13F);

        // R2: stored bits, out-of-range index, key readback
        wr(8'h83, 32'hFFFF_FFFF);
        rd_chk("R2 mask", 8'h83, 32'h13F);
        wr(8'h84, 32'h0000_0024);
        rd_chk("R2 store", 8'h84, 32'h024);
        wr(8'h90, 32'h1);
        rd_chk("R2 beyond", 8'h90, 32'd0);
        wr(8'h01, 32'hDEAD_BEEF);
        rd_chk("R2 key reads zero", 8'h01, 32'd0);

        // R3: lock
        load_key(32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 32'h4444_0000);
        wr(8'h04, 32'h3);
        rd_chk("R3 locked", 8'h05, 32'd1);

        // R4: write ignored while locked, read still works
        wr(8'h84, 32'h13F);
        rd_chk("R4 ignored", 8'h84, 32'h024);

        // R5: wrong key keeps lock, right key opens
        wr(8'h02, 32'h0);
        wr(8'h04, 32'h1);
        rd_chk("R5 wrong key", 8'h05, 32'd1);
        wr(8'h02, 32'h3333_0000);
        wr(8'h04, 32'h1);
        rd_chk("R5 right key", 8'h05, 32'd0);

        // R6: lock+clear stores old key; cleared key then fails
        wr(8'h04, 32'h6);
        rd_chk("R6 locked", 8'h05, 32'd1);
        wr(8'h04, 32'h1);
        rd_chk("R6 cleared key fails", 8'h05, 32'd1);
        load_key(32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 32'h4444_0000);
        wr(8'h04, 32'h1);
        rd_chk("R6 reload opens", 8'h05, 32'd0);

        // R7: decode of mode/kind bits on page 4 (attr 0x024: UR, SR)
        access("R7 user read", page_addr(4, 8), 2'd0, 0, 0);
        access("R7 sup write", page_addr(4, 8), 2'd1, 1, 0);
        access("R7 reserved", page_addr(0, 0), 2'd3, 1, 0);
        fault_chk("R10 first fault");
        // R10: second fault does not overwrite
        access("R10 second deny", page_addr(4, 0), 2'd2, 0, 0);
        fault_chk("R10 hold");
        // R8: local bit clear on page 4
        access("R8 local denied", page_addr(4, 4), 2'd0, 0, 1);
        access("R8 local allowed", page_addr(0, 4), 2'd0, 0, 1);
        // R11: clear
        wr(8'h08, 32'h0);
        fault_chk("R11 cleared");
        // R9: range
        access("R9 below base", BASE - 32'd4, 2'd0, 1, 0);
        fault_chk("R9 oor status");
        access("R9 past end", page_addr(NP, 0), 2'd0, 1, 0);
        access("R9 last page", page_addr(NP - 1, 32'hFFC), 2'd0, 1, 0);
        // R11: clear and deny in same cycle captures the new one
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h08;
        acc_valid = 1'b1; acc_addr = page_addr(NP + 2, 0); acc_kind = 2'd1;
        acc_super = 1'b0; acc_local = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; acc_valid = 1'b0;
        m_fheld = 1'b1; m_faddr = page_addr(NP + 2, 0);
        m_fstat = {23'd0, 1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 2'd1};
        check("R11 same-cycle deny", 32'(resp_deny), 32'd1);
        fault_chk("R11 same-cycle capture");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int unsigned op;
            op = $urandom % 10;
            if (op < 2) begin
                wr(8'h80 | 8'($urandom % (NP + 2)), $urandom);
            end else if (op == 2) begin
                wr(8'($urandom % 4), ($urandom % 2) ? m_ref[$urandom % 4] : $urandom);
            end else if (op == 3) begin
                wr(8'h04, 32'($urandom % 8));
                rd_chk("R5 random status", 8'h05, 32'(m_locked));
            end else if (op == 4) begin
                wr(8'h08, 32'h0);
                fault_chk("R11 random");
            end else begin
                logic [31:0] a;
                a = BASE - 32'h2000 + 32'($urandom % ((NP + 4) << SH));
                access("R7 random", a, 2'($urandom), 1'($urandom), 1'($urandom));
                if (op == 9) fault_chk("R10 random");
            end
            if (it % 50 == 0) begin
                for (int p = 0; p < NP; p++) rd_chk("R4 random table", 8'h80 | 8'(p), 32'(m_attr[p]));
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule